// File: doc/BRIEF.md
# Two-Channel PWM Timer with Buffered Pairing

This block is a free-running up-counter with a programmable wrap value and two compare channels that shape pulse-width-modulated outputs. Each channel holds a compare value and a small configuration word. The word picks whether the channel is idle, runs on its own (unbuffered), or joins the other channel's value register as a buffered pair. It also picks what a match does to the pin (toggle, drive low, drive high) and whether the counter wrap restores the pin to its pulse level.

In paired mode both value registers feed channel 0. One of them is active and the other is a staging slot. Software loads the next pulse width into the staging slot at any point in a period. The pair swaps roles at the following wrap, so a width change never cuts a period short or stretches it. A sticky wrap flag and one sticky match flag per channel report events. Software clears each flag by writing a one to it.

Top module: `tpwm_timer`

## Requirements
- R1: After reset the counter is stopped at zero, both pins are low, all flags are clear and the pair's active slot is value register 0.
- R2: While running, the count advances by one per cycle. A wrap happens in the cycle the count is at or above the wrap value: the count returns to zero and the wrap flag sets. With wrap value M the period is M+1 cycles.
- R3: Control writes work as follows. Bit 0 is the halt bit, which freezes the count, suppresses wrap and match events, and leaves the pins unchanged. Bit 1 zeroes the count without a wrap event.
- R4: The wrap flag stays set until a control write with bit 2 set. If a wrap and that clearing write fall in the same cycle, the flag ends up set.
- R5: Configuration bits 1:0 give the channel mode: 00 idle with pin low, 01 unbuffered, 10 or 11 buffered. Buffered mode is selected by channel 0's configuration. In buffered mode pin 1 is held low and channel 1's configuration has no effect.
- R6: Configuration bits 3:2 give the match action: 01 toggles the pin, 10 drives it low, 11 drives it high, 00 holds the pin low. A match is the cycle in which the count takes the channel's compare value.
- R7: With configuration bit 4 set, a wrap drives the pin to its pulse level, which is the complement of the match action (a toggle action toggles instead). A match in the same cycle overrides it, so a compare value of 0 gives 0% duty.
- R8: With a drive-low action and the wrap restore enabled, the pin is high for C of every M+1 cycles for a compare value C ≤ M. A compare value above M gives 100% duty and never matches.
- R9: A match sets the channel's sticky flag. A configuration write with bit 5 set clears it, and a match in the same cycle wins.
- R10: In buffered mode a write to the active value register takes effect at once. A write to the staging register is held until the next wrap, where the two swap roles and the new width governs the period that starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdata | input | CNT_W | Shared write data for all strobes |
| we_ctl | input | 1 | Control write: bit 0 halt, bit 1 zero count, bit 2 clear wrap flag |
| we_mod | input | 1 | Wrap value write |
| we_val0 | input | 1 | Value register 0 write |
| we_val1 | input | 1 | Value register 1 write |
| we_cfg0 | input | 1 | Channel 0 configuration write (bit 5 clears its match flag) |
| we_cfg1 | input | 1 | Channel 1 configuration write (bit 5 clears its match flag) |
| pwm_pin | output | 2 | Channel output pins |
| ovf_flag | output | 1 | Sticky wrap flag |
| cmp_flag | output | 2 | Sticky per-channel match flags |

## Verification
Two pairs of events can coincide. The first is a wrap and a clearing write to the wrap flag. The bench zeroes the count, counts exactly M cycles and lands the clearing strobe on the wrap edge. The flag must read set afterwards, and a later plain clear must empty it. The second is a staging write and the active compare in the same period. A staging write placed one cycle before the old width's match must leave that period at the old width. The following period must carry the new width, and a later write to the now-active register must reshape the period it lands in.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_UNBUF = 2'b01,
      MODE_BUF   = 2'b10,
      MODE_BUF2  = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_CLEAR  = 2'b10,
      ACT_SET    = 2'b11
   } act_e;

   typedef struct packed {
      logic  restore;
      act_e  act;
      mode_e mode;
   } chcfg_t;

   localparam int CFG_W       = 5;
   localparam int CFG_FLAGCLR = 5;
   localparam int CTL_HALT    = 0;
   localparam int CTL_ZERO    = 1;
   localparam int CTL_OVFCLR  = 2;

endpackage

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic             halt_in,
   input  logic             zero_in,
   input  logic [CNT_W-1:0] mod_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             ev_ok,
   output logic             ovf_evt
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             halt_q;
   logic [CNT_W-1:0] cnt_q;
   logic             zero;

   assign zero    = ctl_we & zero_in;
   assign ev_ok   = ~halt_q & ~zero;
   assign ovf_evt = ev_ok & (cnt_q >= mod_q);

   always_comb begin
      if (zero)         cnt_nxt = '0;
      else if (halt_q)  cnt_nxt = cnt_q;
      else if (ovf_evt) cnt_nxt = '0;
      else              cnt_nxt = cnt_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b1;
         cnt_q  <= '0;
      end else begin
         if (ctl_we) halt_q <= halt_in;
         cnt_q <= cnt_nxt;
      end
   end

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_q && !zero && cnt_q == mod_q) |=> cnt_q == '0);
   assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !zero) |=> $stable(cnt_q));
   assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      zero |=> cnt_q == '0);

endmodule

// File: rtl/tpwm_bufpair.sv
module tpwm_bufpair #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buf_en,
   input  logic             we0,
   input  logic             we1,
   input  logic [CNT_W-1:0] wdata,
   input  logic             ovf_evt,
   output logic [CNT_W-1:0] cmp0,
   output logic [CNT_W-1:0] cmp1
);
   logic [CNT_W-1:0] val0_q, val1_q;
   logic             sel_q, pend_q;
   logic             wr_stage, swap;

   assign wr_stage = buf_en & (sel_q ? we0 : we1);
   assign swap     = buf_en & ovf_evt & pend_q;

   always_comb begin
      if (!buf_en)       cmp0 = val0_q;
      else if (swap)     cmp0 = sel_q ? val0_q : val1_q;
      else               cmp0 = sel_q ? val1_q : val0_q;
   end
   assign cmp1 = val1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val0_q <= '0;
         val1_q <= '0;
         sel_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (we0) val0_q <= wdata;
         if (we1) val1_q <= wdata;
         if (!buf_en) begin
            sel_q  <= 1'b0;
            pend_q <= 1'b0;
         end else if (swap) begin
            sel_q  <= ~sel_q;
            pend_q <= 1'b0;
         end else begin
            pend_q <= pend_q | wr_stage;
         end
      end
   end

   assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_en && !ovf_evt) |=> (!buf_en || $stable(sel_q)));
   assert_stage_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_en && wr_stage && !ovf_evt) |=> (!buf_en || pend_q));

endmodule

// File: rtl/tpwm_channel.sv
module tpwm_channel
   import tpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chcfg_t           cfg,
   input  logic             en,
   input  logic             ev_ok,
   input  logic             ovf_evt,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             flag_clr,
   output logic             pin,
   output logic             flag
);
   logic out_q, out_n, match;

   assign match = en & ev_ok & (cnt_nxt == cmp_val);

   always_comb begin
      out_n = out_q;
      if (en && ovf_evt && cfg.restore) begin
         unique case (cfg.act)
            ACT_TOGGLE: out_n = ~out_q;
            ACT_CLEAR:  out_n = 1'b1;
            ACT_SET:    out_n = 1'b0;
            default:    out_n = out_q;
         endcase
      end
      if (match) begin
         unique case (cfg.act)
            ACT_TOGGLE: out_n = ~out_n;
            ACT_CLEAR:  out_n = 1'b0;
            ACT_SET:    out_n = 1'b1;
            default:    out_n = out_n;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
         flag  <= 1'b0;
      end else begin
         out_q <= out_n;
         if (match)         flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end

   assign pin = en & (cfg.act != ACT_NONE) & out_q;

   assert_match_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (match && cfg.act == ACT_CLEAR) |=> !out_q);
   assert_match_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (match && cfg.act == ACT_SET) |=> out_q);
   assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ovf_evt && cfg.restore && cfg.act == ACT_CLEAR && !match) |=> out_q);
   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);

endmodule

// File: rtl/tpwm_timer.sv
module tpwm_timer
   import tpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] wdata,
   input  logic             we_ctl,
   input  logic             we_mod,
   input  logic             we_val0,
   input  logic             we_val1,
   input  logic             we_cfg0,
   input  logic             we_cfg1,
   output logic [1:0]       pwm_pin,
   output logic             ovf_flag,
   output logic [1:0]       cmp_flag
);
   localparam int NCH = 2;

   if (CNT_W < CFG_FLAGCLR + 1) begin : g_width_check
      $error("tpwm_timer: CNT_W too narrow for configuration word");
   end

   logic [CNT_W-1:0] mod_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             ev_ok, ovf_evt, buf_en;
   chcfg_t           cfg_q [NCH];
   logic [NCH-1:0]   we_cfg, ch_en;
   logic [CNT_W-1:0] cmp_v [NCH];

   assign we_cfg = {we_cfg1, we_cfg0};
   assign buf_en = cfg_q[0].mode[1];
   assign ch_en[0] = (cfg_q[0].mode != MODE_OFF);
   assign ch_en[1] = (cfg_q[1].mode != MODE_OFF) & ~buf_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q    <= '1;
         ovf_flag <= 1'b0;
      end else begin
         if (we_mod) mod_q <= wdata;
         if (ovf_evt)                         ovf_flag <= 1'b1;
         else if (we_ctl && wdata[CTL_OVFCLR]) ovf_flag <= 1'b0;
      end
   end

   tpwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_we  (we_ctl),
      .halt_in (wdata[CTL_HALT]),
      .zero_in (wdata[CTL_ZERO]),
      .mod_q   (mod_q),
      .cnt_nxt (cnt_nxt),
      .ev_ok   (ev_ok),
      .ovf_evt (ovf_evt)
   );

   tpwm_bufpair #(.CNT_W(CNT_W)) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .buf_en  (buf_en),
      .we0     (we_val0),
      .we1     (we_val1),
      .wdata   (wdata),
      .ovf_evt (ovf_evt),
      .cmp0    (cmp_v[0]),
      .cmp1    (cmp_v[1])
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cfg_q[i] <= '0;
         else if (we_cfg[i]) cfg_q[i] <= chcfg_t'(wdata[CFG_W-1:0]);
      end

      tpwm_channel #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg      (cfg_q[i]),
         .en       (ch_en[i]),
         .ev_ok    (ev_ok),
         .ovf_evt  (ovf_evt),
         .cnt_nxt  (cnt_nxt),
         .cmp_val  (cmp_v[i]),
         .flag_clr (we_cfg[i] & wdata[CFG_FLAGCLR]),
         .pin      (pwm_pin[i]),
         .flag     (cmp_flag[i])
      );
   end

   assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !(we_ctl && wdata[CTL_OVFCLR])) |=> ovf_flag);
   assert_ovf_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag);
   assert_pair_pin1_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_en && !we_cfg[0]) |=> !pwm_pin[1]);

endmodule

// File: tb/tb_tpwm_timer.sv
module tb_tpwm_timer;
   localparam int W = 16;
   localparam int T_CTL = 0, T_MOD = 1, T_V0 = 2, T_V1 = 3, T_C0 = 4, T_C1 = 5;

   typedef struct packed {
      logic       ch;
      logic [7:0] modv;
      logic [7:0] cmpv;
      logic [1:0] act;
      logic       rst;
      logic [7:0] exp_hi;
      logic [3:0] exp_rise;
      logic       exp_flag;
   } vec_t;

   // act: 01 toggle, 10 drive low, 11 drive high; window is 4 periods
   localparam vec_t VECS [8] = '{
      '{1'b0, 8'd9,  8'd5,  2'b10, 1'b1, 8'd20, 4'd4, 1'b1},  // R8 50%
      '{1'b0, 8'd9,  8'd0,  2'b10, 1'b1, 8'd0,  4'd0, 1'b1},  // R7 0%
      '{1'b1, 8'd9,  8'd10, 2'b10, 1'b1, 8'd40, 4'd0, 1'b0},  // R8 100%
      '{1'b1, 8'd7,  8'd3,  2'b11, 1'b1, 8'd20, 4'd4, 1'b1},  // R6 drive high
      '{1'b0, 8'd4,  8'd4,  2'b10, 1'b1, 8'd16, 4'd4, 1'b1},  // R8 C = M
      '{1'b1, 8'd9,  8'd3,  2'b01, 1'b0, 8'd20, 4'd2, 1'b1},  // R6 toggle
      '{1'b0, 8'd15, 8'd1,  2'b10, 1'b1, 8'd4,  4'd4, 1'b1},  // R8 narrow
      '{1'b0, 8'd9,  8'd9,  2'b10, 1'b1, 8'd36, 4'd4, 1'b1}   // R8 C = M
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] wdata = '0;
   logic         we_ctl = 0, we_mod = 0, we_val0 = 0, we_val1 = 0, we_cfg0 = 0, we_cfg1 = 0;
   logic [1:0]   pwm_pin;
   logic         ovf_flag;
   logic [1:0]   cmp_flag;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   tpwm_timer #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .wdata(wdata),
      .we_ctl(we_ctl), .we_mod(we_mod), .we_val0(we_val0), .we_val1(we_val1),
      .we_cfg0(we_cfg0), .we_cfg1(we_cfg1),
      .pwm_pin(pwm_pin), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // called at a negedge; strobe is sampled at the next posedge; returns one negedge later
   task automatic wr(input int tgt, input logic [W-1:0] d);
      wdata = d;
      case (tgt)
         T_CTL:   we_ctl  = 1'b1;
         T_MOD:   we_mod  = 1'b1;
         T_V0:    we_val0 = 1'b1;
         T_V1:    we_val1 = 1'b1;
         T_C0:    we_cfg0 = 1'b1;
         default: we_cfg1 = 1'b1;
      endcase
      @(negedge clk);
      {we_ctl, we_mod, we_val0, we_val1, we_cfg0, we_cfg1} = '0;
   endtask

   task automatic measure(input int n, output int hi0, output int hi1);
      hi0 = 0;
      hi1 = 0;
      for (int k = 0; k < n; k++) begin
         if (pwm_pin[0]) hi0++;
         if (pwm_pin[1]) hi1++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int h0, h1, per, hi, rises;
      logic prev, s, held;
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1 pins", int'(pwm_pin), 0);
      check("R1 ovf flag", int'(ovf_flag), 0);
      check("R1 cmp flags", int'(cmp_flag), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check("R1 halted after reset", int'(ovf_flag), 0);

      // vector table
      for (int v = 0; v < 8; v++) begin
         per = int'(VECS[v].modv) + 1;
         wr(T_CTL, 16'h0003);
         wr(T_MOD, W'(VECS[v].modv));
         wr(VECS[v].ch ? T_V1 : T_V0, W'(VECS[v].cmpv));
         wr(VECS[v].ch ? T_C0 : T_C1, 16'h0020);
         wr(VECS[v].ch ? T_C1 : T_C0,
            16'h0021 | W'({VECS[v].rst, VECS[v].act, 2'b00}));
         wr(T_CTL, 16'h0000);
         repeat (3 * per) @(negedge clk);
         hi = 0;
         rises = 0;
         prev = pwm_pin[VECS[v].ch];
         for (int k = 0; k < 4 * per; k++) begin
            @(negedge clk);
            s = pwm_pin[VECS[v].ch];
            if (s) hi++;
            if (s && !prev) rises++;
            prev = s;
         end
         check($sformatf("R8 R6 R7 duty vec %0d", v), hi, int'(VECS[v].exp_hi));
         check($sformatf("R2 R6 period vec %0d", v), rises, int'(VECS[v].exp_rise));
         check($sformatf("R9 match flag vec %0d", v), int'(cmp_flag[VECS[v].ch]),
               int'(VECS[v].exp_flag));
      end

      // R3 halt freezes pins and suppresses wraps
      wr(T_CTL, 16'h0001);
      wr(T_CTL, 16'h0005);
      held = pwm_pin[0];
      hi = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (pwm_pin[0] != held) hi++;
      end
      check("R3 pin frozen while halted", hi, 0);
      check("R3 no wrap while halted", int'(ovf_flag), 0);

      // R2 / R4 wrap timing and same-cycle set versus clear
      wr(T_CTL, 16'h0003);
      wr(T_MOD, 16'd9);
      wr(T_CTL, 16'h0005);
      wr(T_CTL, 16'h0002);
      repeat (9) @(negedge clk);
      check("R2 no wrap before M+1 cycles", int'(ovf_flag), 0);
      wr(T_CTL, 16'h0004);
      check("R4 set wins over clear", int'(ovf_flag), 1);
      wr(T_CTL, 16'h0004);
      check("R4 write-one clears", int'(ovf_flag), 0);
      repeat (8) @(negedge clk);
      check("R2 flag stays clear mid-period", int'(ovf_flag), 0);
      @(negedge clk);
      check("R2 wrap after M+1 cycles", int'(ovf_flag), 1);
      repeat (5) @(negedge clk);
      check("R4 flag sticky", int'(ovf_flag), 1);

      // R10 / R5 buffered pair
      wr(T_CTL, 16'h0003);
      wr(T_MOD, 16'd9);
      wr(T_V0, 16'd2);
      wr(T_V1, 16'd0);
      wr(T_C1, 16'h0019);
      wr(T_C0, 16'h001A);
      wr(T_CTL, 16'h0002);
      repeat (10) @(negedge clk);
      measure(10, h0, h1);
      check("R10 initial width", h0, 2);
      check("R5 pin1 low in pair", h1, 0);
      fork
         measure(10, h0, h1);
         wr(T_V1, 16'd7);
      join
      check("R10 staging write held", h0, 2);
      measure(10, h0, h1);
      check("R10 width after handover", h0, 7);
      check("R5 pin1 ignores cfg1", h1, 0);
      fork
         measure(10, h0, h1);
         wr(T_V1, 16'd4);
      join
      check("R10 active write immediate", h0, 4);
      measure(10, h0, h1);
      check("R10 width kept", h0, 4);

      // R9 flag clear versus R5 idle
      wr(T_C0, 16'h0020);
      check("R9 flag cleared", int'(cmp_flag[0]), 0);
      repeat (30) @(negedge clk);
      check("R5 idle pin low", int'(pwm_pin[0]), 0);
      check("R5 idle no match", int'(cmp_flag[0]), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule